// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a CAN frame that has just finished arriving is handed to the host. Each received frame is always written into a background receive buffer first. When the frame-complete strobe arrives, the identifier bytes of the frame are compared with a bank of programmable acceptance bytes. A matching bank of mask bytes can exclude any identifier bit from the comparison. A frame that passes raises a one-cycle accept pulse and a buffer-swap pulse, and it sets a sticky host-valid flag. A frame that fails produces no output at all, and the next reception simply overwrites it.

The number of identifier bytes compared depends on the frame format. Extended frames use all four bytes. Standard frames use only the first two, and the last two bytes of the identifier, acceptance bank and mask bank are left out. The host writes the eight filter bytes through a small byte-wide write port. It clears the host-valid flag with an acknowledge. When an accepted frame arrives while the flag is still set, the block reports an overrun.

Top module: `can_id_filter`

## Requirements
- R1: After reset all eight filter bytes hold 0x00, and acc_pulse, buf_swap, host_valid and overrun are all 0. In this state an extended frame with identifier 0 is accepted and any nonzero identifier is rejected.
- R2: For an extended frame (rx_ext=1), the frame is accepted if, for every identifier byte i from 0 to 3, each bit either equals the matching bit of acceptance byte i or has its bit in mask byte i set. Identifier byte i sits on rx_id[8i+7:8i].
- R3: For a standard frame (rx_ext=0), only identifier bytes 0 and 1 are compared. Bytes 2 and 3 of the identifier, the acceptance bank and the mask bank have no effect on the decision.
- R4: A mask bit of 1 makes its identifier bit don't-care. A mask bit of 0 requires the identifier bit to equal the acceptance bit.
- R5: acc_pulse and buf_swap are both 1 for one cycle, on the clock after an rx_done cycle whose frame passes. A failing frame, or a cycle without rx_done, leaves both at 0.
- R6: host_valid becomes 1 together with acc_pulse and holds until a cycle with host_ack=1 and no new accept. A new accept in the same cycle as host_ack keeps it at 1.
- R7: overrun is 1 for one cycle, alongside acc_pulse, when a frame is accepted while host_valid is 1 and host_ack is 0 in the strobe cycle.
- R8: Filter writes use cfg_addr values 0 to 3 for acceptance bytes 0 to 3 and values 4 to 7 for mask bytes 0 to 3. A write in the same cycle as rx_done does not affect that frame; it applies from the next strobe on.
- R9: The three low bits of mask byte 1 are used exactly as programmed, including for standard frames. Written as 0, they make identifier bits 8 to 10 take part in the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Filter byte write enable |
| cfg_addr | input | 3 | Filter byte select: 0-3 acceptance, 4-7 mask |
| cfg_wdata | input | 8 | Filter byte write data |
| rx_id | input | 32 | Identifier bytes of the received frame, byte i at [8i+7:8i] |
| rx_ext | input | 1 | 1 = extended frame, 0 = standard frame |
| rx_done | input | 1 | Frame-complete strobe, one cycle |
| host_ack | input | 1 | Host acknowledge, clears host_valid |
| acc_pulse | output | 1 | Frame accepted, one cycle |
| buf_swap | output | 1 | Hand the background buffer to the host, one cycle |
| host_valid | output | 1 | Sticky frame-available flag for the host |
| overrun | output | 1 | An accepted frame arrived while host_valid was still set |

## Verification
The directed frames are chosen in pairs that differ in a single identifier bit. They cover the following cases:
- A bit flipped in byte 3 tells the extended path apart from the standard path.
- A flip in byte 0 under a partial mask separates masked bits from compared bits.
- A flip at bit 8 of a standard frame shows whether mask byte 1 is honoured as written or forced.
- A filter write landing on the strobe cycle shows whether the compare uses the old settings or the new ones.

Ack timing is varied around accepted frames, so that a set flag, a set flag cleared in the same cycle, and a free flag each show whether overrun follows. A long randomized run then mixes formats, writes and acks, and it is compared on every clock against a behavioural model.

// File: rtl/can_acf_pkg.sv
package can_acf_pkg;
  localparam int unsigned ACF_ID_BYTES  = 4;
  localparam int unsigned ACF_STD_BYTES = 2;
  localparam int unsigned ACF_BYTE_W    = 8;
endpackage

// File: rtl/can_acf_regs.sv
module can_acf_regs #(
  parameter int unsigned NUM_BYTES = 4,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned ADDR_W    = $clog2(2 * NUM_BYTES)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [BYTE_W-1:0]                 wdata_i,
  output logic [NUM_BYTES-1:0][BYTE_W-1:0]  acc_o,
  output logic [NUM_BYTES-1:0][BYTE_W-1:0]  msk_o
);
  logic [NUM_BYTES-1:0][BYTE_W-1:0] acc_q, acc_d;
  logic [NUM_BYTES-1:0][BYTE_W-1:0] msk_q, msk_d;

  always_comb begin
    acc_d = acc_q;
    msk_d = msk_q;
    for (int i = 0; i < int'(NUM_BYTES); i++) begin
      if (we_i && addr_i == ADDR_W'(i))
        acc_d[i] = wdata_i;
      if (we_i && addr_i == ADDR_W'(int'(NUM_BYTES) + i))
        msk_d[i] = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      msk_q <= '0;
    end else if (we_i) begin
      acc_q <= acc_d;
      msk_q <= msk_d;
    end
  end

  assign acc_o = acc_q;
  assign msk_o = msk_q;

  // R8: without a write the filter bank keeps its contents
  p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we_i) |-> ($stable(acc_q) && $stable(msk_q)));
endmodule

// File: rtl/can_acf_match.sv
module can_acf_match #(
  parameter int unsigned NUM_BYTES = 4,
  parameter int unsigned STD_BYTES = 2,
  parameter int unsigned BYTE_W    = 8
) (
  input  logic [NUM_BYTES*BYTE_W-1:0]       id_i,
  input  logic                              ext_i,
  input  logic [NUM_BYTES-1:0][BYTE_W-1:0]  acc_i,
  input  logic [NUM_BYTES-1:0][BYTE_W-1:0]  msk_i,
  output logic                              hit_o
);
  logic [NUM_BYTES-1:0] byte_ok;
  logic [NUM_BYTES-1:0] byte_used;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] bit_ok;
    assign bit_ok       = ~(id_i[b*BYTE_W +: BYTE_W] ^ acc_i[b]) | msk_i[b];
    assign byte_ok[b]   = &bit_ok;
    if (b < STD_BYTES) begin : g_always
      assign byte_used[b] = 1'b1;
    end else begin : g_ext_only
      assign byte_used[b] = ext_i;
    end
  end

  assign hit_o = &(byte_ok | ~byte_used);

  // R4: a fully masked compared byte can never veto the frame
  always_comb begin
    for (int b = 0; b < int'(NUM_BYTES); b++)
      p_full_mask_r4: assert (!(&msk_i[b]) || byte_ok[b]);
  end
endmodule

// File: rtl/can_acf_notify.sv
module can_acf_notify (
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  input  logic hit_i,
  input  logic ack_i,
  output logic acc_o,
  output logic swap_o,
  output logic valid_o,
  output logic ovr_o
);
  logic acc_q, acc_d;
  logic valid_q, valid_d;
  logic ovr_q, ovr_d;
  logic take;

  always_comb begin
    take    = done_i && hit_i;
    acc_d   = take;
    valid_d = take || (valid_q && !ack_i);
    ovr_d   = take && valid_q && !ack_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= 1'b0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      valid_q <= valid_d;
      ovr_q   <= ovr_d;
    end
  end

  assign acc_o   = acc_q;
  assign swap_o  = acc_q;
  assign valid_o = valid_q;
  assign ovr_o   = ovr_q;

  p_acc_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |-> $past(done_i));
  p_valid_with_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |-> valid_q);
  p_valid_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ack_i) |=> valid_q);
  p_ovr_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> (acc_q && $past(valid_q) && !$past(ack_i)));
endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
  import can_acf_pkg::*;
#(
  parameter int unsigned NUM_BYTES = ACF_ID_BYTES,
  parameter int unsigned STD_BYTES = ACF_STD_BYTES,
  parameter int unsigned BYTE_W    = ACF_BYTE_W,
  localparam int unsigned ADDR_W   = $clog2(2 * NUM_BYTES),
  localparam int unsigned ID_W     = NUM_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [BYTE_W-1:0] cfg_wdata,
  input  logic [ID_W-1:0]   rx_id,
  input  logic              rx_ext,
  input  logic              rx_done,
  input  logic              host_ack,
  output logic              acc_pulse,
  output logic              buf_swap,
  output logic              host_valid,
  output logic              overrun
);
  logic [NUM_BYTES-1:0][BYTE_W-1:0] acc_bank;
  logic [NUM_BYTES-1:0][BYTE_W-1:0] msk_bank;
  logic                             id_hit;

  can_acf_regs #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .addr_i(cfg_addr),
    .wdata_i(cfg_wdata), .acc_o(acc_bank), .msk_o(msk_bank)
  );

  can_acf_match #(.NUM_BYTES(NUM_BYTES), .STD_BYTES(STD_BYTES), .BYTE_W(BYTE_W)) u_match (
    .id_i(rx_id), .ext_i(rx_ext), .acc_i(acc_bank), .msk_i(msk_bank), .hit_o(id_hit)
  );

  can_acf_notify u_notify (
    .clk(clk), .rst_n(rst_n), .done_i(rx_done), .hit_i(id_hit), .ack_i(host_ack),
    .acc_o(acc_pulse), .swap_o(buf_swap), .valid_o(host_valid), .ovr_o(overrun)
  );

  // R5: no output pulse without a strobe in the previous cycle
  p_swap_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_swap |-> $past(rx_done));
endmodule

// File: tb/tb_can_id_filter.sv
module tb_can_id_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic [31:0] rx_id;
  logic        rx_ext, rx_done, host_ack;
  logic        acc_pulse, buf_swap, host_valid, overrun;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  can_id_filter dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rx_id(rx_id), .rx_ext(rx_ext), .rx_done(rx_done),
    .host_ack(host_ack), .acc_pulse(acc_pulse), .buf_swap(buf_swap),
    .host_valid(host_valid), .overrun(overrun)
  );

  // behavioural reference model
  logic [7:0] m_acc [4];
  logic [7:0] m_msk [4];
  bit e_acc, e_valid, e_ovr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 4; b++) begin m_acc[b] = 8'h00; m_msk[b] = 8'h00; end
      e_acc = 0; e_valid = 0; e_ovr = 0;
    end else begin
      bit hit;
      hit = rx_done;
      if (rx_done)
        for (int b = 0; b < 4; b++)
          if (b < 2 || rx_ext)
            for (int k = 0; k < 8; k++)
              if (!m_msk[b][k] && rx_id[b*8+k] != m_acc[b][k]) hit = 0;
      e_ovr   = hit && e_valid && !host_ack;
      e_valid = hit || (e_valid && !host_ack);
      e_acc   = hit;
      if (cfg_we) begin
        if (cfg_addr < 4) m_acc[cfg_addr] = cfg_wdata;
        else              m_msk[cfg_addr - 4] = cfg_wdata;
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk(acc_pulse == e_acc,   "R5 acc_pulse", 32'(acc_pulse), 32'(e_acc));
    chk(buf_swap == e_acc,    "R5 buf_swap",  32'(buf_swap),  32'(e_acc));
    chk(host_valid == e_valid,"R6 host_valid",32'(host_valid),32'(e_valid));
    chk(overrun == e_ovr,     "R7 overrun",   32'(overrun),   32'(e_ovr));
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(input logic [31:0] id, input bit ext, input bit exp, input string tag);
    @(negedge clk);
    rx_id = id; rx_ext = ext; rx_done = 1;
    @(negedge clk);
    rx_done = 0;
    #1 chk(acc_pulse == exp, tag, 32'(acc_pulse), 32'(exp));
  endtask

  task automatic ack();
    @(negedge clk);
    host_ack = 1;
    @(negedge clk);
    host_ack = 0;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    rx_id = 0; rx_ext = 0; rx_done = 0; host_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({acc_pulse, buf_swap, host_valid, overrun} == 4'b0, "R1 reset outputs",
        32'({acc_pulse, buf_swap, host_valid, overrun}), 32'h0);
    send(32'h0, 1, 1, "R1 zero id accepted");
    send(32'h0000_0100, 1, 0, "R1 nonzero id rejected");
    ack();

    wr(0, 8'h12); wr(1, 8'h34); wr(2, 8'h56); wr(3, 8'h78);
    send(32'h7856_3412, 1, 1, "R2 exact extended match");
    ack();
    send(32'hF856_3412, 1, 0, "R2 byte3 bit flip rejected");
    send(32'h0000_3412, 0, 1, "R3 standard ignores bytes 2-3");
    ack();
    send(32'h7856_3512, 0, 0, "R3 standard byte1 mismatch");
    send(32'h7856_3512, 1, 0, "R9 bit8 compared with mask1 low bits zero");
    wr(5, 8'h07);
    send(32'h0000_3512, 0, 1, "R9 bit8 free after mask1 low bits set");
    ack();

    wr(4, 8'hF0);
    send(32'h7856_34E2, 1, 1, "R4 masked upper nibble differs");
    ack();
    send(32'h7856_3413, 1, 0, "R4 unmasked lower bit differs");

    // R6 hold and clear
    send(32'h0000_3412, 0, 1, "R6 accept sets valid");
    repeat (4) @(negedge clk);
    #1 chk(host_valid == 1, "R6 valid held", 32'(host_valid), 32'h1);
    // R7 overrun while set
    send(32'h0000_3412, 0, 1, "R7 second accept");
    #0 chk(overrun == 1, "R7 overrun pulse", 32'(overrun), 32'h1);
    @(negedge clk);
    #1 chk(overrun == 0, "R7 overrun one cycle", 32'(overrun), 32'h0);
    // ack in strobe cycle: valid stays, no overrun
    @(negedge clk);
    rx_id = 32'h0000_3412; rx_ext = 0; rx_done = 1; host_ack = 1;
    @(negedge clk);
    rx_done = 0; host_ack = 0;
    #1 chk(overrun == 0 && host_valid == 1, "R6 R7 ack with accept",
           32'({overrun, host_valid}), 32'h1);
    ack();
    #1 chk(host_valid == 0, "R6 ack clears", 32'(host_valid), 32'h0);

    // R8 write coincident with strobe uses old settings
    @(negedge clk);
    rx_id = 32'h0000_3412; rx_ext = 0; rx_done = 1;
    cfg_we = 1; cfg_addr = 0; cfg_wdata = 8'hAA;
    @(negedge clk);
    rx_done = 0; cfg_we = 0;
    #1 chk(acc_pulse == 1, "R8 same-cycle write ignored", 32'(acc_pulse), 32'h1);
    ack();
    send(32'h0000_3412, 0, 0, "R8 write applies next frame");

    // randomized mix, compared every clock
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      cfg_we    = ($urandom_range(0, 7) == 0);
      cfg_addr  = 3'($urandom_range(0, 7));
      cfg_wdata = ($urandom_range(0, 1) == 1) ? 8'hFF : 8'($urandom);
      rx_id     = {8'($urandom_range(0, 3)), 8'($urandom_range(0, 3)),
                   8'($urandom_range(0, 3)), 8'($urandom_range(0, 3))};
      rx_ext    = 1'($urandom_range(0, 1));
      rx_done   = 1'($urandom_range(0, 1));
      host_ack  = ($urandom_range(0, 3) == 0);
    end
    @(negedge clk);
    cfg_we = 0; rx_done = 0; host_ack = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule